// File: doc/BRIEF.md
# Mixed-Width PC-Relative Address Unit

This unit takes instruction halfwords, each with its byte address, one per fetch handshake. It groups them into whole instructions: one halfword for a short instruction, two for a long one. For every finished instruction it produces one registered result. The result holds the assembled instruction word, the address where the instruction starts and a length flag. It also holds the value that software sees when it reads the program counter, and the word-aligned copy of that value that PC-relative addressing uses. Finally it holds the effective address, which is that aligned base plus a signed immediate.

A state input selects between two instruction states. In the compact state, instructions are 16 or 32 bits long. In the fixed state, every instruction is a 32-bit word. The program counter always reads a fixed distance ahead of the current instruction, and that distance depends only on the state, never on the instruction's length. The address arithmetic uses a separate copy of the program counter, rounded down to a multiple of four, so the unit reports both values.

Top module: `pcrel_addr_unit`

## Requirements
- R1: In the compact state (`fixed_state`=0), `out_pc` equals `out_addr` + 4, for both 16-bit and 32-bit instructions.
- R2: In the fixed state (`fixed_state`=1), `out_pc` equals `out_addr` + 8.
- R3: `out_base` equals `out_pc` with its two low bits cleared.
- R4: `out_ea` equals `out_base` plus the sign-extended `imm_off`, wrapping modulo 2^32. The offset used is the one presented with the halfword that completes the instruction. Negative offsets and odd results are allowed.
- R5: In the compact state, a first halfword whose value is 0xE800 or above (top five bits 11101, 11110 or 11111) starts a 32-bit instruction. Any other first halfword is a complete instruction on its own: it yields `out_len32`=0, with the halfword in `out_instr[15:0]` and zeros in `out_instr[31:16]`.
- R6: A 32-bit compact-state instruction places its first-fetched halfword in `out_instr[31:16]` and the second in `out_instr[15:0]`, with `out_len32`=1.
- R7: In the fixed state, every instruction takes two halfwords, and a 16-bit instruction is never produced. The first-fetched halfword goes to `out_instr[15:0]` and the second to `out_instr[31:16]`, with `out_len32`=1.
- R8: The result appears with `out_valid` high for exactly one cycle, one clock edge after the handshake that completes the instruction. Accepting only the first halfword of a long instruction produces no result.
- R9: `out_addr` is the byte address of the instruction's first halfword.
- R10: A synchronous reset discards any half-assembled instruction and drives `out_valid` low. `hw_ready` is low while reset is asserted and high otherwise.
- R11: The instruction state is taken from the cycle in which the instruction's first halfword is accepted. A change of `fixed_state` before the second halfword does not affect that instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fixed_state | input | 1 | 1 = fixed 32-bit state, 0 = compact 16/32-bit state |
| hw_valid | input | 1 | A halfword is offered |
| hw_ready | output | 1 | The unit takes a halfword this cycle |
| hw_data | input | 16 | Instruction halfword |
| hw_addr | input | 32 | Byte address of the halfword |
| imm_off | input | 12 | Signed immediate offset, two's complement |
| out_valid | output | 1 | One-cycle strobe marking a finished instruction |
| out_instr | output | 32 | Assembled instruction word |
| out_addr | output | 32 | Address of the instruction |
| out_len32 | output | 1 | 1 = 32-bit instruction, 0 = 16-bit |
| out_pc | output | 32 | Value the program counter reads as |
| out_base | output | 32 | Word-aligned base for PC-relative addressing |
| out_ea | output | 32 | Base plus signed offset |

## Verification
All results of an instruction, including the addresses, the instruction word and the strobe, come out of a single register. They are therefore due at the first rising edge after the handshake that completes the instruction, and a first halfword alone produces nothing. The bench keeps a behavioural model that is updated on each rising edge from the inputs accepted at that edge. It compares the unit's outputs with this model at the following falling edge, so every result is checked in the cycle it is due and checked again as absent in every other cycle. Inputs change shortly after each rising edge, which keeps both the model and the comparison clear of the clock edge.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;

  // instruction state encoding
  typedef enum logic {
    ST_COMPACT = 1'b0,
    ST_FIXED   = 1'b1
  } isa_state_e;

  // distance the program counter reads ahead of the current instruction
  localparam int unsigned AHEAD_COMPACT = 4;
  localparam int unsigned AHEAD_FIXED   = 8;

  // true when a compact-state first halfword opens a 32-bit instruction
  function automatic logic opens_long(input logic [15:0] hw);
    return (hw[15:11] == 5'b11101) || (hw[15:11] == 5'b11110) ||
           (hw[15:11] == 5'b11111);
  endfunction

endpackage

// File: rtl/hw_assembler.sv
module hw_assembler
  import pcrel_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  isa_state_e    mode_in,
  input  logic [15:0]   hw_data,
  input  logic [AW-1:0] hw_addr,
  input  logic [OW-1:0] hw_off,
  output logic          done,
  output logic          wide_start,
  output logic          pend,
  output logic [31:0]   instr,
  output logic [AW-1:0] iaddr,
  output logic          len32,
  output isa_state_e    imode,
  output logic [OW-1:0] ioff
);

  logic [15:0]   first_hw;
  logic [AW-1:0] first_addr;
  isa_state_e    first_mode;

  // a lone first halfword needs a partner when fixed, or when it opens a long one
  assign wide_start = acc && !pend &&
                      ((mode_in == ST_FIXED) || opens_long(hw_data));
  assign done       = acc && !wide_start;
  assign imode      = pend ? first_mode : mode_in;
  assign iaddr      = pend ? first_addr : hw_addr;
  assign len32      = pend;
  assign ioff       = hw_off;

  always_comb begin
    if (!pend)
      instr = {16'h0000, hw_data};
    else if (first_mode == ST_FIXED)
      instr = {hw_data, first_hw};
    else
      instr = {first_hw, hw_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      first_hw   <= '0;
      first_addr <= '0;
      first_mode <= ST_COMPACT;
    end else if (wide_start) begin
      pend       <= 1'b1;
      first_hw   <= hw_data;
      first_addr <= hw_addr;
      first_mode <= mode_in;
    end else if (acc) begin
      pend       <= 1'b0;
    end
  end

  // R8
  hold_first_chk: assert property (@(posedge clk) disable iff (rst)
    wide_start |=> pend);

  // R10
  reset_drop_chk: assert property (@(posedge clk) rst |=> !pend);

endmodule

// File: rtl/pc_calc.sv
module pc_calc
  import pcrel_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input  logic [AW-1:0] iaddr,
  input  isa_state_e    imode,
  input  logic [OW-1:0] ioff,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] base,
  output logic [AW-1:0] ea
);

  localparam int XW = AW - OW;

  function automatic logic [AW-1:0] pc_read(input logic [AW-1:0] a,
                                            input isa_state_e m);
    logic [AW-1:0] ahead;
    ahead = (m == ST_FIXED) ? AW'(AHEAD_FIXED) : AW'(AHEAD_COMPACT);
    return a + ahead;
  endfunction

  function automatic logic [AW-1:0] word_floor(input logic [AW-1:0] v);
    return {v[AW-1:2], 2'b00};
  endfunction

  function automatic logic [AW-1:0] add_signed(input logic [AW-1:0] b,
                                               input logic [OW-1:0] o);
    return b + {{XW{o[OW-1]}}, o};
  endfunction

  assign pc   = pc_read(iaddr, imode);
  assign base = word_floor(pc);
  assign ea   = add_signed(base, ioff);

endmodule

// File: rtl/pcrel_addr_unit.sv
module pcrel_addr_unit
  import pcrel_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fixed_state,
  input  logic          hw_valid,
  output logic          hw_ready,
  input  logic [15:0]   hw_data,
  input  logic [AW-1:0] hw_addr,
  input  logic [OW-1:0] imm_off,
  output logic          out_valid,
  output logic [31:0]   out_instr,
  output logic [AW-1:0] out_addr,
  output logic          out_len32,
  output logic [AW-1:0] out_pc,
  output logic [AW-1:0] out_base,
  output logic [AW-1:0] out_ea
);

  logic          acc, done, wide_start, pend, len32;
  logic [31:0]   instr;
  logic [AW-1:0] iaddr, pc, base, ea;
  logic [OW-1:0] ioff;
  isa_state_e    mode_in, imode;
  isa_state_e    out_mode_q;

  assign hw_ready = !rst;
  assign acc      = hw_valid && hw_ready;
  assign mode_in  = fixed_state ? ST_FIXED : ST_COMPACT;

  hw_assembler #(.AW(AW), .OW(OW)) i_asm (
    .clk(clk), .rst(rst), .acc(acc), .mode_in(mode_in),
    .hw_data(hw_data), .hw_addr(hw_addr), .hw_off(imm_off),
    .done(done), .wide_start(wide_start), .pend(pend),
    .instr(instr), .iaddr(iaddr), .len32(len32), .imode(imode), .ioff(ioff)
  );

  pc_calc #(.AW(AW), .OW(OW)) i_calc (
    .iaddr(iaddr), .imode(imode), .ioff(ioff),
    .pc(pc), .base(base), .ea(ea)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_instr  <= '0;
      out_addr   <= '0;
      out_len32  <= 1'b0;
      out_pc     <= '0;
      out_base   <= '0;
      out_ea     <= '0;
      out_mode_q <= ST_COMPACT;
    end else begin
      out_valid <= done;
      if (done) begin
        out_instr  <= instr;
        out_addr   <= iaddr;
        out_len32  <= len32;
        out_pc     <= pc;
        out_base   <= base;
        out_ea     <= ea;
        out_mode_q <= imode;
      end
    end
  end

  // R1
  compact_ahead_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode_q == ST_COMPACT) |-> (out_pc - out_addr) == AW'(4));

  // R2
  fixed_ahead_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode_q == ST_FIXED) |-> (out_pc - out_addr) == AW'(8));

  // R3
  base_floor_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_base[1:0] == 2'b00 && (out_pc - out_base) < AW'(4)));

  // R5
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_len32) |-> out_instr[31:16] == 16'h0000);

  // R7
  fixed_len_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode_q == ST_FIXED) |-> out_len32);

  // R8
  no_early_out_chk: assert property (@(posedge clk) disable iff (rst)
    wide_start |=> !out_valid);

  // R10
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

endmodule

// File: tb/test_pcrel_addr_unit.sv
module test_pcrel_addr_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fixed_state = 1'b0;
  logic        hw_valid = 1'b0;
  logic        hw_ready;
  logic [15:0] hw_data = '0;
  logic [31:0] hw_addr = '0;
  logic [11:0] imm_off = '0;
  logic        out_valid, out_len32;
  logic [31:0] out_instr, out_addr, out_pc, out_base, out_ea;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  pcrel_addr_unit i_pcrel_addr_unit (
    .clk(clk), .rst(rst), .fixed_state(fixed_state),
    .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_data(hw_data),
    .hw_addr(hw_addr), .imm_off(imm_off),
    .out_valid(out_valid), .out_instr(out_instr), .out_addr(out_addr),
    .out_len32(out_len32), .out_pc(out_pc), .out_base(out_base), .out_ea(out_ea)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit          m_hold;
  bit [15:0]   m_first;
  longint      m_addr0;
  bit          m_fix0;
  bit          e_valid;
  bit [31:0]   e_instr, e_addr, e_pc, e_base, e_ea;
  bit          e_len32, e_fix;

  always @(posedge clk) begin
    e_valid = 0;
    if (rst) begin
      m_hold = 0;
    end else if (hw_valid) begin
      longint a; bit fx; longint pcv; longint bs;
      if (!m_hold && (fixed_state || hw_data >= 16'hE800)) begin
        m_hold = 1; m_first = hw_data; m_addr0 = hw_addr; m_fix0 = fixed_state;
      end else begin
        if (m_hold) begin
          a = m_addr0; fx = m_fix0; e_len32 = 1;
          e_instr = fx ? {hw_data, m_first} : {m_first, hw_data};
        end else begin
          a = hw_addr; fx = 0; e_len32 = 0;
          e_instr = {16'h0, hw_data};
        end
        m_hold = 0;
        pcv = a + (fx ? 8 : 4);
        bs = (pcv / 4) * 4;
        e_valid = 1; e_fix = fx;
        e_addr = 32'(a); e_pc = 32'(pcv); e_base = 32'(bs);
        e_ea = 32'(bs + longint'($signed(imm_off)));
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R10 hw_ready", 32'(hw_ready), 32'(!rst));
      chk("R8 out_valid", 32'(out_valid), 32'(e_valid));
      if (e_valid && out_valid) begin
        chk(e_fix ? "R2 pc" : "R1 pc", out_pc, e_pc);
        chk("R3 base", out_base, e_base);
        chk("R4 ea", out_ea, e_ea);
        chk(e_fix ? "R7 instr" : (e_len32 ? "R6 instr" : "R5 instr"), out_instr, e_instr);
        chk("R5 len32", 32'(out_len32), 32'(e_len32));
        chk("R9 addr", out_addr, e_addr);
      end
    end
  end

  task automatic put(input logic [15:0] d, input logic [31:0] a,
                     input int off, input bit fx);
    @(posedge clk); #2;
    hw_valid = 1; hw_data = d; hw_addr = a; imm_off = 12'(off); fixed_state = fx;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; hw_valid = 0;
    end
  endtask

  task automatic finish_run;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    idle(3);
    // R10 reset state
    chk("R10 out_valid at reset", 32'(out_valid), 32'd0);
    @(posedge clk); #2; rst = 0;
    // compact examples: copy of PC at 0x1598, long loads with negative offsets
    put(16'h467B, 32'h1598, 0, 0);           // R1: pc 0x159C
    put(16'hF8BF, 32'h159A, 0, 0);           // R6 first half, R8 no output
    put(16'h4000, 32'h159C, 0, 0);           // R3: pc 0x159E base 0x159C
    put(16'h46F9, 32'h159E, 0, 0);
    put(16'hF83F, 32'h15A0, 0, 0);
    put(16'h5001, 32'h15A2, -1, 0);          // R4: ea 0x15A3
    put(16'hF83F, 32'h15A4, 0, 0);
    put(16'h6002, 32'h15A6, -2, 0);
    put(16'hF83F, 32'h15A8, 0, 0);
    put(16'h7003, 32'h15AA, -3, 0);
    put(16'hF83F, 32'h15AC, 0, 0);
    put(16'h8004, 32'h15AE, -4, 0);
    // R5 boundary: 0xE7FF is short, 0xE800 opens a long one
    put(16'hE7FF, 32'h2000, 5, 0);
    put(16'hE800, 32'h2002, 0, 0);
    idle(2);                                  // R8 gap while holding
    put(16'h1234, 32'h2004, -2048, 0);
    // R2 / R7 fixed state
    put(16'hBEEF, 32'h3000, 0, 1);
    put(16'hDEAD, 32'h3002, 16, 1);
    put(16'h0001, 32'h3004, 0, 1);
    put(16'h0002, 32'h3006, -9, 1);
    // R11 mode change between halves
    put(16'h1111, 32'h4000, 0, 1);
    put(16'h2222, 32'h4002, 3, 0);
    put(16'hF000, 32'h4004, 0, 0);
    put(16'h3333, 32'h4006, 7, 1);
    // R10 reset while holding a first halfword
    put(16'hF123, 32'h5000, 0, 0);
    @(posedge clk); #2; hw_valid = 0; rst = 1;
    @(posedge clk); #2; rst = 0;
    put(16'h0042, 32'h5010, 1, 0);           // must come out as short
    // mixed random stream
    begin
      logic [31:0] a;
      a = 32'h8000;
      for (int i = 0; i < 400; i++) begin
        bit fx;
        logic [15:0] d;
        fx = ($urandom_range(0, 7) == 0);
        d = 16'($urandom);
        if (fx) begin
          if (a[1]) a = a + 2;
          put(d, a, 0, 1); a = a + 2;
          put(16'($urandom), a, $urandom_range(0, 4095) - 2048, 1); a = a + 2;
        end else if (d >= 16'hE800) begin
          put(d, a, 0, 0); a = a + 2;
          if ($urandom_range(0, 3) == 0) idle(1);
          put(16'($urandom), a, $urandom_range(0, 4095) - 2048, 0); a = a + 2;
        end else begin
          put(d, a, $urandom_range(0, 4095) - 2048, 0); a = a + 2;
        end
        if ($urandom_range(0, 5) == 0) idle(1);
      end
    end
    idle(3);
    finish_run();
  end

endmodule